// File: doc/BRIEF.md
# Dual-Rail Elastic Store with Phase-Steered Read Clock

This block takes a gapped or jittery dual-rail transmit bit stream (a positive rail and a negative rail), stores it in a small elastic buffer, and replays it at a smooth rate. Writes arrive as single-cycle strobes derived from the incoming transmit clock. Reads are paced by a phase accumulator that runs on one fast system clock. Each carry out of the accumulator is one sub-step, and a nominal bit lasts eight sub-steps.

The block never corrects fill drift by dropping or repeating bits. When the buffer is close to full, the next read bit is one sub-step shorter. When it is close to empty, the next read bit is one sub-step longer. This forms a digital loop that centres the fill level. After reset the buffer sits half full, so the average delay through it is half its depth. If the pointers collide anyway, a sticky error flag is raised.

Top module: `jitter_elastic_store`

## Requirements
- R1: While reset is low, and at its release, `fill` equals DEPTH/2 (16) and `rd_pos`, `rd_neg`, `rd_stb` and `err` are all 0.
- R2: Bits are read out in the order they were written, with the rails kept as a pair. The first DEPTH/2 reads after reset return `rd_pos`=0 and `rd_neg`=0.
- R3: `fill` equals DEPTH/2, plus accepted writes, minus completed reads since reset. It never exceeds DEPTH.
- R4: A sub-step tick is the carry out of an ACC_W-bit accumulator that adds `rate_step` every clock. A nominal bit lasts 8 ticks. `rd_stb` is high for exactly one clock, in the clock after the tick that ends a bit. The first strobe after reset follows the 8th tick.
- R5: If `fill` is DEPTH-2 or more in the clock where `rd_stb` is high, the next bit lasts 7 ticks.
- R6: If `fill` is 2 or less in the clock where `rd_stb` is high, the next bit lasts 9 ticks. Otherwise the next bit lasts 8 ticks. This gives at most one adjustment per bit.
- R7: A write that arrives when `fill` equals DEPTH, and in a clock with no read, is discarded and sets `err`.
- R8: A read that comes due when `fill` is 0 still pulses `rd_stb`. The rails keep their previous values, `fill` is not decremented, and `err` is set.
- R9: Once set, `err` stays at 1 until reset.
- R10: `rd_pos` and `rd_neg` change only in clocks where `rd_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe, one clock per incoming bit |
| wr_pos | input | 1 | Positive-rail bit to store |
| wr_neg | input | 1 | Negative-rail bit to store |
| rate_step | input | ACC_W (16) | Phase increment added each clock; sets the sub-step rate |
| rd_stb | output | 1 | One-clock pulse marking a new output bit |
| rd_pos | output | 1 | Dejittered positive-rail bit |
| rd_neg | output | 1 | Dejittered negative-rail bit |
| fill | output | $clog2(DEPTH)+1 (6) | Entries currently held |
| err | output | 1 | Sticky flag for a pointer collision |

## Verification
The assertions assume the following about the inputs:
- `wr_stb` is already a synchronous pulse in the system clock domain.
- `rate_step` stays constant between resets, so each bit spans a whole number of equally spaced ticks.
- There is at most one tick per clock, so strobes are at least seven clocks apart.

The stimulus keeps to these assumptions. It changes `rate_step` only while reset is held. It picks tick periods that are powers of two, from 2 to 16 clocks. It drives writes as isolated pulses or as continuous bursts, with gap patterns that are steady, jittered, slightly fast or slightly slow. This pushes the fill into the near-full band, the near-empty band and both collision cases.

// File: rtl/jitter_elastic_store.sv
module jitter_elastic_store #(
  parameter int DEPTH    = 32,
  parameter int ACC_W    = 16,
  parameter int SUBSTEPS = 8,
  parameter int MARGIN   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             wr_pos,
  input  logic             wr_neg,
  input  logic [ACC_W-1:0] rate_step,
  output logic             rd_stb,
  output logic             rd_pos,
  output logic             rd_neg,
  output logic [$clog2(DEPTH):0] fill,
  output logic             err
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(SUBSTEPS + 2);
  localparam logic [AW:0]   FULL     = (AW+1)'(DEPTH);
  localparam logic [AW:0]   HALF     = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0]   HI_MARK  = (AW+1)'(DEPTH - MARGIN);
  localparam logic [AW:0]   LO_MARK  = (AW+1)'(MARGIN);
  localparam logic [SW-1:0] LEN_NOM  = SW'(SUBSTEPS);
  localparam logic [SW-1:0] LEN_FAST = SW'(SUBSTEPS - 1);
  localparam logic [SW-1:0] LEN_SLOW = SW'(SUBSTEPS + 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   acc_sum;
  logic             tick;
  logic [SW-1:0]    sub, bit_len;
  logic             rd_fire, wr_ok, rd_ok;
  logic [AW:0]      wr_ptr, rd_ptr;
  logic [1:0]       mem [DEPTH];

  assign acc_sum = {1'b0, acc} + {1'b0, rate_step};
  assign tick    = acc_sum[ACC_W];
  assign rd_fire = tick && (sub == bit_len - 1'b1);
  assign fill    = wr_ptr - rd_ptr;
  assign wr_ok   = wr_stb && ((fill != FULL) || rd_fire);
  assign rd_ok   = rd_fire && (fill != '0);

  // phase accumulator and bit timing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      sub     <= '0;
      bit_len <= LEN_NOM;
    end else begin
      acc <= acc_sum[ACC_W-1:0];
      if (rd_fire)   sub <= '0;
      else if (tick) sub <= sub + 1'b1;
      if (rd_stb) begin
        if (fill >= HI_MARK)      bit_len <= LEN_FAST;
        else if (fill <= LO_MARK) bit_len <= LEN_SLOW;
        else                      bit_len <= LEN_NOM;
      end
    end
  end

  // storage and pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 2'b00;
      wr_ptr <= HALF;
      rd_ptr <= '0;
      rd_stb <= 1'b0;
      rd_pos <= 1'b0;
      rd_neg <= 1'b0;
      err    <= 1'b0;
    end else begin
      rd_stb <= rd_fire;
      if (wr_ok) begin
        mem[wr_ptr[AW-1:0]] <= {wr_pos, wr_neg};
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (rd_ok) begin
        {rd_pos, rd_neg} <= mem[rd_ptr[AW-1:0]];
        rd_ptr <= rd_ptr + 1'b1;
      end
      if ((wr_stb && !wr_ok) || (rd_fire && !rd_ok)) err <= 1'b1;
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);
  // R3
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill) == fill) || ($past(fill) + 1'b1 == fill) || (fill + 1'b1 == $past(fill)));
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);
  // R7
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && fill == FULL && !rd_fire) |=> err);
  // R8
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && fill == '0) |=> (err && rd_stb && $stable({rd_pos, rd_neg})));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R10
  rails_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> $stable({rd_pos, rd_neg}));
endmodule

// File: tb/sim_jitter_elastic_store.sv
module sim_jitter_elastic_store;
  localparam int CLK_T = 10;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, wr_pos = 1'b0, wr_neg = 1'b0;
  logic [15:0] rate_step = 16'd32768;
  logic rd_stb, rd_pos, rd_neg, err;
  logic [5:0] fill;

  jitter_elastic_store u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_pos(wr_pos), .wr_neg(wr_neg),
    .rate_step(rate_step), .rd_stb(rd_stb), .rd_pos(rd_pos), .rd_neg(rd_neg),
    .fill(fill), .err(err));

  always #(CLK_T/2) clk = ~clk;

  int nvec = 0, nfail = 0;
  int T = 2;
  int cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  logic wr_seen = 1'b0, rst_seen = 1'b0;
  logic [1:0] wd_seen = 2'b00;
  always @(posedge clk) begin
    wr_seen  <= wr_stb;
    wd_seen  <= {wr_pos, wr_neg};
    rst_seen <= rst_n;
  end

  logic [1:0] q[$];
  logic [1:0] last_d, expd;
  int pf, exp_fill, cyc, last_cyc, exp_len;
  bit exp_err, have_stb;

  always @(negedge clk) begin
    if (!rst_seen) begin
      q.delete();
      for (int i = 0; i < DEPTH/2; i++) q.push_back(2'b00);
      pf = DEPTH/2; exp_err = 0; last_d = 2'b00; cyc = 0; last_cyc = 0;
      have_stb = 0; exp_len = 8;
      chk(fill == 6'(DEPTH/2), "R1 fill", int'(fill), DEPTH/2);
      chk({rd_stb, rd_pos, rd_neg, err} == 4'b0, "R1 outputs", int'({rd_stb, rd_pos, rd_neg, err}), 0);
    end else begin
      cyc++;
      exp_fill = pf;
      if (rd_stb) begin
        if (pf > 0) begin
          expd = q.pop_front();
          exp_fill--;
          chk({rd_pos, rd_neg} == expd, "R2 data", int'({rd_pos, rd_neg}), int'(expd));
          last_d = expd;
        end else begin
          exp_err = 1;
          chk({rd_pos, rd_neg} == last_d, "R8 held data", int'({rd_pos, rd_neg}), int'(last_d));
        end
        if (!have_stb)
          chk(cyc == 8*T, "R4 first strobe", cyc, 8*T);
        else if (exp_len == 7)
          chk(cyc - last_cyc == 7*T, "R5 short bit", cyc - last_cyc, 7*T);
        else if (exp_len == 9)
          chk(cyc - last_cyc == 9*T, "R6 long bit", cyc - last_cyc, 9*T);
        else
          chk(cyc - last_cyc == 8*T, "R4 nominal bit", cyc - last_cyc, 8*T);
        have_stb = 1;
        last_cyc = cyc;
        exp_len = (int'(fill) >= DEPTH-2) ? 7 : (int'(fill) <= 2) ? 9 : 8;
      end else begin
        chk({rd_pos, rd_neg} == last_d, "R10 rails steady", int'({rd_pos, rd_neg}), int'(last_d));
      end
      if (wr_seen) begin
        if (pf == DEPTH && !rd_stb) exp_err = 1;
        else begin
          q.push_back(wd_seen);
          exp_fill++;
        end
      end
      chk(int'(fill) == exp_fill, "R3 fill", int'(fill), exp_fill);
      chk(err == exp_err, "R9 err", int'(err), int'(exp_err));
      pf = exp_fill;
    end
  end

  task automatic start(input int t);
    @(negedge clk);
    rst_n = 1'b0; wr_stb = 1'b0;
    T = t;
    rate_step = 16'(65536 / t);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic next_data();
    cnt++;
    wr_pos = cnt[0] ^ cnt[3];
    wr_neg = cnt[1] ^ cnt[4];
  endtask

  task automatic write_gap(input int gap);
    @(negedge clk);
    wr_stb = 1'b1; next_data();
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_stb = 1'b1; next_data();
    end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_T * 150000);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    // R2 R4: jittered writer at the nominal average rate
    start(2);
    for (int i = 0; i < 300; i++) begin
      case (i % 6)
        0: write_gap(10); 1: write_gap(22); 2: write_gap(16);
        3: write_gap(12); 4: write_gap(20); default: write_gap(16);
      endcase
    end
    // sweep of tick periods, writer near nominal with small jitter
    for (int k = 1; k <= 4; k++) begin
      start(1 << k);
      for (int i = 0; i < 120; i++)
        write_gap(8 * (1 << k) + ((i % 3) - 1) * (1 << (k - 1)));
    end
    // R7: continuous burst overruns the buffer
    start(2);
    burst(60);
    repeat (600) @(negedge clk);
    chk(err == 1'b1, "R7 overflow flag", int'(err), 1);
    // R8: no writes at all drains the buffer
    start(4);
    repeat (1600) @(negedge clk);
    chk(err == 1'b1, "R8 underflow flag", int'(err), 1);
    chk(fill == 6'd0, "R8 fill stays empty", int'(fill), 0);
    // R5: slightly fast writer settles in the near-full band
    start(2);
    for (int i = 0; i < 400; i++) write_gap(15);
    chk(err == 1'b0, "R5 no collision", int'(err), 0);
    // R6: slightly slow writer settles in the near-empty band
    start(2);
    for (int i = 0; i < 400; i++) write_gap(17);
    chk(err == 1'b0, "R6 no collision", int'(err), 0);
    repeat (50) @(negedge clk);
    summary();
  end
endmodule